// File: doc/BRIEF.md
# Four-Level Vectored Interrupt Controller

This block arbitrates six interrupt requests for a small 8-bit processor core. Each source carries an individual enable and a pair of priority bits that together select one of four levels. A global enable masks every request. Among the pending, enabled sources the block chooses the one at the highest level, breaking ties with a fixed polling order. It then presents that source's fixed vector address and its level to the core, one clock after the inputs are seen.

The controller records which levels are in service. The core pulses an acknowledge input when it takes the offered interrupt, and that marks the winner's level as in service. A return pulse releases the highest level in service. A new request is offered only when its level is strictly above every level in service, so a level-3 handler is never interrupted. Two of the sources merge a pair of flags each. Apart from arbitration, the two external interrupts produce a wake-up request for leaving power-down.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_req`, `wake_req` and `in_svc` are all 0.
- R2: Source 4 requests when either `uart_tx_flag` or `uart_rx_flag` is 1. Source 5 requests when either `tmr2_ovf_flag` or `tmr2_ext_flag` is 1. The other sources are, by index 0..3, `ext0_flag`, `tmr0_flag`, `ext1_flag` and `tmr1_flag`.
- R3: A source takes part only when its bit in `src_en` is 1 and `glb_en` is 1. With `glb_en` at 0, `irq_req` is 0.
- R4: Among the candidates, the one with the numerically largest level wins.
- R5: Among candidates at the same level, the lowest source index wins (0 first, 5 last).
- R6: `irq_vec` is 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 or 0x003B for winning source 0 through 5, and it is valid whenever `irq_req` is 1.
- R7: The level of source i is {`prio_hi[i]`, `prio_lo[i]`}. Level 3 is the highest. `irq_lvl` shows the winner's level.
- R8: A candidate is offered only if its level is strictly greater than the highest level set in `in_svc`. With level 3 in service, nothing is offered.
- R9: `ack` while `irq_req` is 1 sets bit `irq_lvl` of `in_svc` (bit k stands for level k) and forces `irq_req` to 0 in the next cycle.
- R10: A `reti` pulse clears only the highest set bit of `in_svc`.
- R11: `wake_req` is 1 exactly when (`ext0_flag` and `src_en[0]`) or (`ext1_flag` and `src_en[2]`) held in the previous cycle, whatever `glb_en` is. No other source wakes.
- R12: `irq_req`, `irq_vec`, `irq_lvl` and `wake_req` are registered. They reflect the inputs of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext0_flag | input | 1 | External interrupt 0 flag (source 0) |
| tmr0_flag | input | 1 | Timer 0 overflow flag (source 1) |
| ext1_flag | input | 1 | External interrupt 1 flag (source 2) |
| tmr1_flag | input | 1 | Timer 1 overflow flag (source 3) |
| uart_tx_flag | input | 1 | Serial transmit flag (source 4) |
| uart_rx_flag | input | 1 | Serial receive flag (source 4) |
| tmr2_ovf_flag | input | 1 | Timer 2 overflow flag (source 5) |
| tmr2_ext_flag | input | 1 | Timer 2 external flag (source 5) |
| src_en | input | 6 | Per-source enable, bit i for source i |
| glb_en | input | 1 | Global interrupt enable |
| prio_lo | input | 6 | Low priority bit per source |
| prio_hi | input | 6 | High priority bit per source |
| ack | input | 1 | Core takes the offered interrupt |
| reti | input | 1 | Return from interrupt pulse |
| irq_req | output | 1 | Interrupt offered to the core |
| irq_vec | output | 16 | Vector address of the offered source |
| irq_lvl | output | 2 | Level of the offered source |
| in_svc | output | 4 | In-service levels, bit k for level k |
| wake_req | output | 1 | Wake-up request from power-down |

## Verification
The assertions assume that the core pulses `ack` only while `irq_req` is 1. They also assume that `reti` comes only while some level is in service, and never in the same cycle as `ack`. The bench drives `ack` and `reti` only from sequences that first observe `irq_req` high or `in_svc` non-zero. It holds both at 0 during the arbitration, masking and wake-up sweeps, so the in-service state stays empty there. All inputs change on the falling edge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC = 6;
  localparam int LVLW = 2;
  localparam int NLVL = 1 << LVLW;
  localparam int IDXW = $clog2(NSRC);
  localparam int VECW = 16;
  localparam int VBASE = 3;
  localparam int VSTEP_SH = 3;
  localparam int LAST_SLOT = 7;

  // level from the paired priority bits, high bit most significant
  function automatic logic [LVLW-1:0] level_of(input logic hi, input logic lo);
    return {hi, lo};
  endfunction

  // vectors step by 8 from 3; the last source sits in slot 7
  function automatic logic [VECW-1:0] vector_of(input logic [IDXW-1:0] idx);
    logic [VECW-1:0] slot;
    slot = (idx == IDXW'(NSRC - 1)) ? VECW'(LAST_SLOT) : VECW'(idx);
    return VECW'(VBASE) + (slot << VSTEP_SH);
  endfunction

  // lowest level still allowed to preempt (NLVL means none)
  function automatic logic [LVLW:0] floor_of(input logic [NLVL-1:0] svc);
    logic [LVLW:0] f;
    f = '0;
    for (int k = 0; k < NLVL; k++)
      if (svc[k]) f = (LVLW + 1)'(k + 1);
    return f;
  endfunction

  // drop the highest in-service level
  function automatic logic [NLVL-1:0] top_clear(input logic [NLVL-1:0] svc);
    logic [NLVL-1:0] r;
    logic found;
    r = svc;
    found = 1'b0;
    for (int k = NLVL - 1; k >= 0; k--)
      if (!found && svc[k]) begin
        r[k] = 1'b0;
        found = 1'b1;
      end
    return r;
  endfunction
endpackage

// File: rtl/irq_req_merge.sv
module irq_req_merge
  import prio_irq_pkg::*;
(
  input  logic            ext0_flag,
  input  logic            tmr0_flag,
  input  logic            ext1_flag,
  input  logic            tmr1_flag,
  input  logic            uart_tx_flag,
  input  logic            uart_rx_flag,
  input  logic            tmr2_ovf_flag,
  input  logic            tmr2_ext_flag,
  output logic [NSRC-1:0] raw_req
);
  assign raw_req = {tmr2_ovf_flag | tmr2_ext_flag,
                    uart_tx_flag | uart_rx_flag,
                    tmr1_flag, ext1_flag, tmr0_flag, ext0_flag};
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import prio_irq_pkg::*;
(
  input  logic [NSRC-1:0] raw_req,
  input  logic [NSRC-1:0] src_en,
  input  logic            glb_en,
  input  logic [NSRC-1:0] prio_lo,
  input  logic [NSRC-1:0] prio_hi,
  input  logic [LVLW:0]   floor_lvl,
  output logic            win_vld,
  output logic [IDXW-1:0] win_idx,
  output logic [LVLW-1:0] win_lvl
);
  localparam int KW = 1 + LVLW + IDXW;

  // key = {valid, level, inverted index}: the largest key wins
  logic [KW-1:0] key [NSRC];
  logic [KW-1:0] best;

  for (genvar g = 0; g < NSRC; g++) begin : g_key
    logic [LVLW-1:0] lv;
    logic            ok;
    assign lv = level_of(prio_hi[g], prio_lo[g]);
    assign ok = raw_req[g] & src_en[g] & glb_en & ({1'b0, lv} >= floor_lvl);
    assign key[g] = ok ? {1'b1, lv, IDXW'(NSRC - 1 - g)} : '0;
  end

  always_comb begin
    best = '0;
    for (int i = 0; i < NSRC; i++)
      if (key[i] > best) best = key[i];
    win_vld = best[KW-1];
    win_lvl = best[KW-2 -: LVLW];
    win_idx = IDXW'(NSRC - 1) - best[IDXW-1:0];
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_evt,
  input  logic [LVLW-1:0] set_lvl,
  input  logic            clr_evt,
  output logic [NLVL-1:0] in_svc,
  output logic [LVLW:0]   floor_lvl
);
  logic [NLVL-1:0] kept;
  logic [NLVL-1:0] added;

  assign kept  = clr_evt ? top_clear(in_svc) : in_svc;
  assign added = set_evt ? (NLVL'(1) << set_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) in_svc <= '0;
    else        in_svc <= kept | added;
  end

  assign floor_lvl = floor_of(in_svc);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext0_flag,
  input  logic            tmr0_flag,
  input  logic            ext1_flag,
  input  logic            tmr1_flag,
  input  logic            uart_tx_flag,
  input  logic            uart_rx_flag,
  input  logic            tmr2_ovf_flag,
  input  logic            tmr2_ext_flag,
  input  logic [NSRC-1:0] src_en,
  input  logic            glb_en,
  input  logic [NSRC-1:0] prio_lo,
  input  logic [NSRC-1:0] prio_hi,
  input  logic            ack,
  input  logic            reti,
  output logic            irq_req,
  output logic [VECW-1:0] irq_vec,
  output logic [LVLW-1:0] irq_lvl,
  output logic [NLVL-1:0] in_svc,
  output logic            wake_req
);
  logic [NSRC-1:0] raw_req;
  logic [LVLW:0]   floor_lvl;
  logic            win_vld;
  logic [IDXW-1:0] win_idx;
  logic [LVLW-1:0] win_lvl;

  // named events for the checker
  logic grant_evt;
  logic retire_evt;
  logic wake_now;

  assign grant_evt  = ack & irq_req;
  assign retire_evt = reti;
  assign wake_now   = (ext0_flag & src_en[0]) | (ext1_flag & src_en[2]);

  irq_req_merge u_merge (
    .ext0_flag    (ext0_flag),
    .tmr0_flag    (tmr0_flag),
    .ext1_flag    (ext1_flag),
    .tmr1_flag    (tmr1_flag),
    .uart_tx_flag (uart_tx_flag),
    .uart_rx_flag (uart_rx_flag),
    .tmr2_ovf_flag(tmr2_ovf_flag),
    .tmr2_ext_flag(tmr2_ext_flag),
    .raw_req      (raw_req)
  );

  irq_pick u_pick (
    .raw_req  (raw_req),
    .src_en   (src_en),
    .glb_en   (glb_en),
    .prio_lo  (prio_lo),
    .prio_hi  (prio_hi),
    .floor_lvl(floor_lvl),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  irq_svc_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (grant_evt),
    .set_lvl  (irq_lvl),
    .clr_evt  (retire_evt),
    .in_svc   (in_svc),
    .floor_lvl(floor_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req  <= 1'b0;
      irq_vec  <= '0;
      irq_lvl  <= '0;
      wake_req <= 1'b0;
    end else begin
      // a granted offer is withdrawn so the stale pick is never re-offered
      irq_req  <= win_vld & ~grant_evt;
      irq_vec  <= vector_of(win_idx);
      irq_lvl  <= win_lvl;
      wake_req <= wake_now;
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
  import prio_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            glb_en,
  input logic            grant_evt,
  input logic            retire_evt,
  input logic            wake_now,
  input logic            irq_req,
  input logic [VECW-1:0] irq_vec,
  input logic [LVLW-1:0] irq_lvl,
  input logic [NLVL-1:0] in_svc,
  input logic            wake_req
);
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec == 16'h0003 || irq_vec == 16'h000B || irq_vec == 16'h0013 ||
                 irq_vec == 16'h001B || irq_vec == 16'h0023 || irq_vec == 16'h003B)); // R6

  AST_GLB_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(glb_en) |-> !irq_req); // R3

  AST_ONLY_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((in_svc >> irq_lvl) == '0)); // R8

  AST_ACK_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |=> !irq_req); // R9

  AST_ACK_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_evt && !retire_evt) |=> in_svc[$past(irq_lvl)]); // R9

  AST_RETI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_evt && !grant_evt && in_svc != '0) |=>
      ($countones(in_svc) + 1 == $countones($past(in_svc)))); // R10

  AST_WAKE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(wake_now)); // R11
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en),
  .grant_evt (grant_evt),
  .retire_evt(retire_evt),
  .wake_now  (wake_now),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec),
  .irq_lvl   (irq_lvl),
  .in_svc    (in_svc),
  .wake_req  (wake_req)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext0_flag = 0, tmr0_flag = 0, ext1_flag = 0, tmr1_flag = 0;
  logic uart_tx_flag = 0, uart_rx_flag = 0, tmr2_ovf_flag = 0, tmr2_ext_flag = 0;
  logic [5:0] src_en = '0, prio_lo = '0, prio_hi = '0;
  logic glb_en = 0, ack = 0, reti = 0;
  logic irq_req, wake_req;
  logic [15:0] irq_vec;
  logic [1:0] irq_lvl;
  logic [3:0] in_svc;

  int n_cmp = 0;
  int n_bad = 0;
  int lvl_cfg [6];
  int vtab [6] = '{3, 11, 19, 27, 35, 59};

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ext0_flag(ext0_flag), .tmr0_flag(tmr0_flag), .ext1_flag(ext1_flag), .tmr1_flag(tmr1_flag),
    .uart_tx_flag(uart_tx_flag), .uart_rx_flag(uart_rx_flag),
    .tmr2_ovf_flag(tmr2_ovf_flag), .tmr2_ext_flag(tmr2_ext_flag),
    .src_en(src_en), .glb_en(glb_en), .prio_lo(prio_lo), .prio_hi(prio_hi),
    .ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .in_svc(in_svc), .wake_req(wake_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_levels();
    for (int i = 0; i < 6; i++) begin
      prio_lo[i] = lvl_cfg[i][0];
      prio_hi[i] = lvl_cfg[i][1];
    end
  endtask

  task automatic drive(input logic [5:0] p, input bit rx_sel, input bit ext_sel);
    ext0_flag = p[0]; tmr0_flag = p[1]; ext1_flag = p[2]; tmr1_flag = p[3];
    uart_tx_flag = p[4] & !rx_sel; uart_rx_flag = p[4] & rx_sel;
    tmr2_ovf_flag = p[5] & !ext_sel; tmr2_ext_flag = p[5] & ext_sel;
  endtask

  // scan levels from the top, sources in polling order
  function automatic int model_win(input logic [5:0] req, input logic [5:0] en,
                                   input logic g, input logic [3:0] svc);
    int top = -1;
    for (int k = 0; k < 4; k++) if (svc[k]) top = k;
    if (!g) return -1;
    for (int lv = 3; lv > top; lv--)
      for (int i = 0; i < 6; i++)
        if (req[i] && en[i] && lvl_cfg[i] == lv) return i;
    return -1;
  endfunction

  task automatic chk_arb(input string tag, input int exp);
    check({tag, " irq_req"}, int'(irq_req), int'(exp >= 0));
    if (exp >= 0) begin
      check({tag, " irq_vec"}, int'(irq_vec), vtab[exp]);
      check({tag, " irq_lvl"}, int'(irq_lvl), lvl_cfg[exp]);
    end
  endtask

  task automatic pulse_ack();
    ack = 1; @(negedge clk); ack = 0;
  endtask

  task automatic pulse_reti();
    reti = 1; @(negedge clk); reti = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq_req", int'(irq_req), 0);
    check("R1 wake_req", int'(wake_req), 0);
    check("R1 in_svc", int'(in_svc), 0);

    // R12 registered: nothing before the edge, result after it
    for (int i = 0; i < 6; i++) lvl_cfg[i] = 0;
    load_levels();
    src_en = 6'h3F; glb_en = 1;
    drive(6'b000010, 0, 0);
    #1 check("R12 before edge", int'(irq_req), 0);
    @(negedge clk);
    check("R12 after edge", int'(irq_req), 1);
    check("R12 vec", int'(irq_vec), 11);

    // R2 merged flags, each half alone
    drive(6'b0, 0, 0);
    uart_rx_flag = 1; @(negedge clk); chk_arb("R2 uart rx", 4);
    uart_rx_flag = 0; uart_tx_flag = 1; @(negedge clk); chk_arb("R2 uart tx", 4);
    uart_tx_flag = 0; tmr2_ext_flag = 1; @(negedge clk); chk_arb("R2 t2 ext", 5);
    tmr2_ext_flag = 0; tmr2_ovf_flag = 1; @(negedge clk); chk_arb("R2 t2 ovf", 5);
    tmr2_ovf_flag = 0;

    // R4 R5 R6 R7 sweep of level configurations and request patterns
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int i = 0; i < 6; i++) lvl_cfg[i] = (cfg * (i + 1) + (cfg >> 2) + i) % 4;
      load_levels();
      for (int p = 0; p < 64; p++) begin
        drive(6'(p), cfg[0], cfg[1]);
        @(negedge clk);
        chk_arb("R4 R5 R6 R7 arb", model_win(6'(p), 6'h3F, 1'b1, 4'b0));
      end
    end

    // R3 enable sweep with every source pending at one level
    for (int i = 0; i < 6; i++) lvl_cfg[i] = 1;
    load_levels();
    drive(6'h3F, 0, 0);
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 64; e++) begin
        src_en = 6'(e); glb_en = g[0];
        @(negedge clk);
        chk_arb("R3 mask", model_win(6'h3F, 6'(e), g[0], 4'b0));
      end

    // R11 wake sweep
    for (int g = 0; g < 2; g++)
      for (int ei = 0; ei < 5; ei++)
        for (int p = 0; p < 64; p++) begin
          logic [5:0] en;
          en = (ei == 0) ? 6'h00 : (ei == 1) ? 6'h3F : (ei == 2) ? 6'h01 : (ei == 3) ? 6'h04 : 6'h3A;
          src_en = en; glb_en = g[0];
          drive(6'(p), p[0], p[1]);
          @(negedge clk);
          check("R11 wake", int'(wake_req), int'((p[0] && en[0]) || (p[2] && en[2])));
        end

    // R8 R9 R10 preemption per in-service level
    drive(6'b0, 0, 0); src_en = 6'h3F; glb_en = 1;
    for (int lv = 0; lv < 4; lv++) begin
      lvl_cfg[1] = lv; load_levels();
      tmr0_flag = 1; @(negedge clk);
      chk_arb("R9 offer", 1);
      pulse_ack();
      tmr0_flag = 0;
      check("R9 withdraw", int'(irq_req), 0);
      check("R9 mark", int'(in_svc), 1 << lv);
      for (int m = 0; m < 4; m++) begin
        lvl_cfg[3] = m; load_levels();
        tmr1_flag = 1; @(negedge clk);
        chk_arb("R8 preempt", (m > lv) ? 3 : -1);
        tmr1_flag = 0; @(negedge clk);
      end
      pulse_reti();
      check("R10 release", int'(in_svc), 0);
    end

    // R10 nested levels: return drops only the top one
    lvl_cfg[1] = 1; lvl_cfg[3] = 2; load_levels();
    tmr0_flag = 1; @(negedge clk); pulse_ack(); tmr0_flag = 0;
    tmr1_flag = 1; @(negedge clk);
    chk_arb("R8 nested offer", 3);
    pulse_ack(); tmr1_flag = 0;
    check("R9 nested mark", int'(in_svc), 6);
    pulse_reti();
    check("R10 top only", int'(in_svc), 2);
    tmr1_flag = 1; @(negedge clk);
    chk_arb("R8 after return", 3);
    tmr1_flag = 0;
    pulse_reti();
    check("R10 last", int'(in_svc), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule